// File: doc/BRIEF.md
# Power-Delivery Transmit Handshake Controller

This block sits between a register interface and a byte serializer and runs the software side of sending one power-delivery message. Software programs the number of payload bytes still to send (header included, CRC excluded), feeds data bytes one at a time into a single holding register, and raises either a message-send command or a hard-reset command. The controller counts bytes down, raises a transmit-request flag whenever it can take the next byte, offers bytes to the serializer over a ready/valid pair, and reports how each attempt ended through sticky status flags. Each flag has its own write-one-clear bit and its own interrupt enable.

A send or hard-reset command stays pending until the controller acts on it, and it clears itself on that cycle. If a receive is in progress when a command is taken, the attempt is dropped, and the matching discard flag is raised once the line is quiet. A hard-reset request that arrives while a message is in flight cuts the message short and raises an abort flag. A serializer that asks for a byte when none is buffered causes an underrun, which ends the message. A message that is aborted or ends in underrun never raises the sent flag.

The state machine has five states. IDLE waits for a command. MSG hands out message bytes. HRST drives the hard-reset request to the serializer. DROP_MSG and DROP_HRST wait for the line to go quiet after a dropped attempt. IDLE moves to HRST or DROP_HRST on a pending hard reset, which has priority, and otherwise to MSG or DROP_MSG on a pending send, depending on `rx_busy`. MSG returns to IDLE when the final byte is taken, when the payload is empty, or on underrun. MSG moves to HRST on a hard-reset request. HRST returns to IDLE on `hrst_done`. Each DROP state returns to IDLE once `rx_busy` is low.

Top module: `pd_tx_handshake`

## Requirements
- R1: A payload-count load takes effect only in IDLE. Each accepted data write stores the byte and lowers the count by one. A data write is ignored while the holding register is full, while the count is zero, or in the cycle of a count load.
- R2: `txreq` is high exactly when the holding register is empty and the remaining count is nonzero.
- R3: In MSG, with no hard reset pending, a held byte is shown on `ser_valid`/`ser_data`. `ser_last` marks the byte written when the count reached zero. A cycle with `ser_valid` and `ser_ready` both high empties the holding register.
- R4: `cmd_status` = {hard-reset pending, send pending}. A pending command clears on the cycle IDLE acts on it, or on the cycle MSG takes a hard reset. In IDLE a hard reset is taken before a send, and the send stays pending.
- R5: A command taken while `rx_busy` is high enters a DROP state. Its discard flag (message: bit 1, hard reset: bit 4) is set on the first edge where `rx_busy` is low.
- R6: A hard reset pending in MSG sets the abort flag (bit 2), moves to HRST, clears the count and the holding register, and does not set the sent flag.
- R7: The sent flag (bit 0) is set when the final byte is taken by the serializer. With a zero count and an empty holding register, it is set one cycle after MSG is entered.
- R8: `ser_ready` high in MSG with the holding register empty and a nonzero count sets the underrun flag (bit 5). It ends the message in IDLE with the count cleared and without the sent flag.
- R9: `hrst_go` is high throughout HRST. `hrst_done` there sets the hard-reset-sent flag (bit 3) and returns to IDLE.
- R10: Each bit of `stat` stays set until the same bit of `flag_clr` is written. A new set wins over a clear in the same cycle.
- R11: `irq` is the OR of (`stat` AND `irq_en`) together with (`txreq` AND `txreq_ie`).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| paysz_we | input | 1 | Load payload count |
| paysz_val | input | CNT_W | Payload count value |
| dat_we | input | 1 | Data byte write |
| dat_val | input | DATA_W | Data byte |
| cmd_send | input | 1 | Request message send |
| cmd_hrst | input | 1 | Request hard reset |
| rx_busy | input | 1 | Receive in progress on the line |
| ser_ready | input | 1 | Serializer requests/accepts a byte |
| hrst_done | input | 1 | Serializer finished the hard reset |
| flag_clr | input | 6 | Write-one-clear for status flags |
| irq_en | input | 6 | Interrupt enables for status flags |
| txreq_ie | input | 1 | Interrupt enable for txreq |
| ser_valid | output | 1 | Byte offered to the serializer |
| ser_data | output | DATA_W | Offered byte |
| ser_last | output | 1 | Offered byte is the final one |
| hrst_go | output | 1 | Hard reset request to the serializer |
| txreq | output | 1 | Next data byte wanted |
| cmd_status | output | 2 | Pending {hard reset, send} |
| stat | output | 6 | Sticky status flags |
| irq | output | 1 | Interrupt |

## Verification
A wrong state or a mis-kept pending bit shows at the ports within one cycle of the edge that caused it: `ser_valid`, `hrst_go` or `cmd_status` differs on the very next sample. A drifting byte count shows only when the last byte is offered, because `ser_last` appears a byte early or late, or `txreq` stays up after the final write. Flag errors are sticky, so they remain visible on `stat` and `irq` until cleared, which makes per-cycle comparison against a behavioural model catch them at the first differing cycle.

// File: rtl/pd_tx_pkg.sv
package pd_tx_pkg;

    localparam int NFLAG    = 6;
    localparam int FL_SENT  = 0;
    localparam int FL_DISC  = 1;
    localparam int FL_ABORT = 2;
    localparam int FL_HSENT = 3;
    localparam int FL_HDISC = 4;
    localparam int FL_UNDER = 5;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_MSG,
        ST_HRST,
        ST_DROP_MSG,
        ST_DROP_HRST
    } tx_state_e;

endpackage

// File: rtl/pd_tx_byte_buf.sv
module pd_tx_byte_buf #(
    parameter int CNT_W  = 10,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ld_en,
    input  logic [CNT_W-1:0]  ld_val,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              pop,
    input  logic              flush,
    output logic              full,
    output logic [DATA_W-1:0] data,
    output logic              cnt_zero,
    output logic              txreq
);
    localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

    logic [CNT_W-1:0] cnt_q;
    logic             wr_ok;

    assign cnt_zero = (cnt_q == '0);
    // a byte is accepted only into an empty slot of a nonzero message
    assign wr_ok    = wr_en && !full && !cnt_zero && !ld_en;
    assign txreq    = !full && !cnt_zero;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
            full  <= 1'b0;
            data  <= '0;
        end else if (flush) begin
            cnt_q <= '0;
            full  <= 1'b0;
        end else begin
            if (ld_en)
                cnt_q <= ld_val;
            else if (wr_ok)
                cnt_q <= cnt_q - CNT_ONE;
            if (pop)
                full <= 1'b0;
            else if (wr_ok) begin
                full <= 1'b1;
                data <= wr_data;
            end
        end
    end

endmodule

// File: rtl/pd_tx_status_flags.sv
module pd_tx_status_flags #(
    parameter int N = 6
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] set,
    input  logic [N-1:0] clr,
    output logic [N-1:0] flags
);
    for (genvar i = 0; i < N; i++) begin : g_flag
        always_ff @(posedge clk) begin
            if (!rst_n)
                flags[i] <= 1'b0;
            else if (set[i])
                flags[i] <= 1'b1;
            else if (clr[i])
                flags[i] <= 1'b0;
        end
    end

endmodule

// File: rtl/pd_tx_fsm.sv
module pd_tx_fsm
    import pd_tx_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             send_p,
    input  logic             hrst_p,
    input  logic             rx_busy,
    input  logic             buf_full,
    input  logic             cnt_zero,
    input  logic             ser_ready,
    input  logic             hrst_done,
    output tx_state_e        st,
    output logic             take_s,
    output logic             take_h,
    output logic             flush,
    output logic [NFLAG-1:0] set_fl,
    output logic             ser_valid,
    output logic             hrst_go
);
    tx_state_e nxt;

    always_ff @(posedge clk) begin
        if (!rst_n)
            st <= ST_IDLE;
        else
            st <= nxt;
    end

    always_comb begin
        nxt = st;
        unique case (st)
            ST_IDLE: begin
                if (hrst_p)
                    nxt = rx_busy ? ST_DROP_HRST : ST_HRST;
                else if (send_p)
                    nxt = rx_busy ? ST_DROP_MSG : ST_MSG;
            end
            ST_MSG: begin
                if (hrst_p)
                    nxt = ST_HRST;
                else if (buf_full) begin
                    if (ser_ready && cnt_zero)
                        nxt = ST_IDLE;
                end else if (cnt_zero || ser_ready)
                    nxt = ST_IDLE;
            end
            ST_HRST:      if (hrst_done) nxt = ST_IDLE;
            ST_DROP_MSG:  if (!rx_busy)  nxt = ST_IDLE;
            ST_DROP_HRST: if (!rx_busy)  nxt = ST_IDLE;
            default:      nxt = ST_IDLE;
        endcase
    end

    always_comb begin
        take_s    = 1'b0;
        take_h    = 1'b0;
        flush     = 1'b0;
        set_fl    = '0;
        ser_valid = 1'b0;
        hrst_go   = 1'b0;
        unique case (st)
            ST_IDLE: begin
                if (hrst_p)
                    take_h = 1'b1;
                else if (send_p)
                    take_s = 1'b1;
            end
            ST_MSG: begin
                if (hrst_p) begin
                    take_h           = 1'b1;
                    flush            = 1'b1;
                    set_fl[FL_ABORT] = 1'b1;
                end else if (buf_full) begin
                    ser_valid = 1'b1;
                    if (ser_ready && cnt_zero)
                        set_fl[FL_SENT] = 1'b1;
                end else if (cnt_zero) begin
                    set_fl[FL_SENT] = 1'b1;
                end else if (ser_ready) begin
                    flush            = 1'b1;
                    set_fl[FL_UNDER] = 1'b1;
                end
            end
            ST_HRST: begin
                hrst_go = 1'b1;
                if (hrst_done)
                    set_fl[FL_HSENT] = 1'b1;
            end
            ST_DROP_MSG:  if (!rx_busy) set_fl[FL_DISC]  = 1'b1;
            ST_DROP_HRST: if (!rx_busy) set_fl[FL_HDISC] = 1'b1;
            default: ;
        endcase
    end

endmodule

// File: rtl/pd_tx_handshake.sv
module pd_tx_handshake
    import pd_tx_pkg::*;
#(
    parameter int CNT_W  = 10,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              paysz_we,
    input  logic [CNT_W-1:0]  paysz_val,
    input  logic              dat_we,
    input  logic [DATA_W-1:0] dat_val,
    input  logic              cmd_send,
    input  logic              cmd_hrst,
    input  logic              rx_busy,
    input  logic              ser_ready,
    input  logic              hrst_done,
    input  logic [NFLAG-1:0]  flag_clr,
    input  logic [NFLAG-1:0]  irq_en,
    input  logic              txreq_ie,
    output logic              ser_valid,
    output logic [DATA_W-1:0] ser_data,
    output logic              ser_last,
    output logic              hrst_go,
    output logic              txreq,
    output logic [1:0]        cmd_status,
    output logic [NFLAG-1:0]  stat,
    output logic              irq
);
    tx_state_e        state_q;
    logic             send_p, hrst_p;
    logic             take_s, take_h, flush;
    logic [NFLAG-1:0] set_fl;
    logic             buf_full, cnt_zero, ld_en, pop;

    assign ld_en = paysz_we && (state_q == ST_IDLE);
    assign pop   = ser_valid && ser_ready;

    // pending command bits: a fresh request wins over the self-clear
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            send_p <= 1'b0;
            hrst_p <= 1'b0;
        end else begin
            send_p <= (send_p && !take_s) || cmd_send;
            hrst_p <= (hrst_p && !take_h) || cmd_hrst;
        end
    end

    pd_tx_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .send_p    (send_p),
        .hrst_p    (hrst_p),
        .rx_busy   (rx_busy),
        .buf_full  (buf_full),
        .cnt_zero  (cnt_zero),
        .ser_ready (ser_ready),
        .hrst_done (hrst_done),
        .st        (state_q),
        .take_s    (take_s),
        .take_h    (take_h),
        .flush     (flush),
        .set_fl    (set_fl),
        .ser_valid (ser_valid),
        .hrst_go   (hrst_go)
    );

    pd_tx_byte_buf #(
        .CNT_W  (CNT_W),
        .DATA_W (DATA_W)
    ) u_buf (
        .clk      (clk),
        .rst_n    (rst_n),
        .ld_en    (ld_en),
        .ld_val   (paysz_val),
        .wr_en    (dat_we),
        .wr_data  (dat_val),
        .pop      (pop),
        .flush    (flush),
        .full     (buf_full),
        .data     (ser_data),
        .cnt_zero (cnt_zero),
        .txreq    (txreq)
    );

    pd_tx_status_flags #(
        .N (NFLAG)
    ) u_flags (
        .clk   (clk),
        .rst_n (rst_n),
        .set   (set_fl),
        .clr   (flag_clr),
        .flags (stat)
    );

    assign ser_last   = ser_valid && cnt_zero;
    assign cmd_status = {hrst_p, send_p};
    assign irq        = (|(stat & irq_en)) || (txreq && txreq_ie);

endmodule

// File: rtl/pd_tx_handshake_chk.sv
module pd_tx_handshake_chk
    import pd_tx_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input tx_state_e        st,
    input logic [1:0]       cmd_pend,
    input logic             cmd_send,
    input logic             cmd_hrst,
    input logic             rx_busy,
    input logic             ser_valid,
    input logic             ser_last,
    input logic             txreq,
    input logic             hrst_go,
    input logic [NFLAG-1:0] stat,
    input logic [NFLAG-1:0] flag_clr
);
    p_last_valid_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ser_last |-> ser_valid);

    p_txreq_excl_r2: assert property (@(posedge clk) disable iff (!rst_n)
        txreq |-> !ser_valid);

    p_go_excl_r9: assert property (@(posedge clk) disable iff (!rst_n)
        hrst_go |-> !ser_valid);

    p_hrst_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_IDLE && cmd_pend[1] && !cmd_hrst) |=> !cmd_pend[1]);

    p_send_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_IDLE && cmd_pend[0] && !cmd_pend[1] && !cmd_send) |=> !cmd_pend[0]);

    p_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (($past(stat & ~flag_clr) & ~stat) == '0));

    p_no_sent_on_abort_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(stat[FL_ABORT]) |-> !$rose(stat[FL_SENT]));

    p_disc_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(stat[FL_DISC]) |-> !$past(rx_busy));

endmodule

bind pd_tx_handshake pd_tx_handshake_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .st        (state_q),
    .cmd_pend  (cmd_status),
    .cmd_send  (cmd_send),
    .cmd_hrst  (cmd_hrst),
    .rx_busy   (rx_busy),
    .ser_valid (ser_valid),
    .ser_last  (ser_last),
    .txreq     (txreq),
    .hrst_go   (hrst_go),
    .stat      (stat),
    .flag_clr  (flag_clr)
);

// File: tb/tb_pd_tx_handshake.sv
module tb_pd_tx_handshake;
    import pd_tx_pkg::*;

    localparam int CLK_PERIOD = 10;
    localparam int CNT_W      = 10;
    localparam int DATA_W     = 8;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              paysz_we = 1'b0;
    logic [CNT_W-1:0]  paysz_val = '0;
    logic              dat_we = 1'b0;
    logic [DATA_W-1:0] dat_val = '0;
    logic              cmd_send = 1'b0, cmd_hrst = 1'b0;
    logic              rx_busy = 1'b0, ser_ready = 1'b0, hrst_done = 1'b0;
    logic [NFLAG-1:0]  flag_clr = '0, irq_en = '0;
    logic              txreq_ie = 1'b0;
    logic              ser_valid, ser_last, hrst_go, txreq, irq;
    logic [DATA_W-1:0] ser_data;
    logic [1:0]        cmd_status;
    logic [NFLAG-1:0]  stat;

    int n_chk = 0;
    int n_bad = 0;

    pd_tx_handshake #(.CNT_W(CNT_W), .DATA_W(DATA_W)) dut (
        .clk(clk), .rst_n(rst_n), .paysz_we(paysz_we), .paysz_val(paysz_val),
        .dat_we(dat_we), .dat_val(dat_val), .cmd_send(cmd_send), .cmd_hrst(cmd_hrst),
        .rx_busy(rx_busy), .ser_ready(ser_ready), .hrst_done(hrst_done),
        .flag_clr(flag_clr), .irq_en(irq_en), .txreq_ie(txreq_ie),
        .ser_valid(ser_valid), .ser_data(ser_data), .ser_last(ser_last),
        .hrst_go(hrst_go), .txreq(txreq), .cmd_status(cmd_status),
        .stat(stat), .irq(irq)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    // behavioural reference: 0 idle, 1 message, 2 hard reset, 3 drop msg, 4 drop hrst
    int               m_st = 0;
    int               m_cnt = 0;
    logic             m_full = 1'b0;
    logic [7:0]       m_data = '0;
    logic             m_sp = 1'b0, m_hp = 1'b0;
    logic [NFLAG-1:0] m_fl = '0;

    always @(posedge clk) begin : ref_model
        int ns;
        logic ld, wr, pop, tk_s, tk_h, fl;
        logic [NFLAG-1:0] st_set;
        if (!rst_n) begin
            m_st = 0; m_cnt = 0; m_full = 0; m_data = '0;
            m_sp = 0; m_hp = 0; m_fl = '0;
        end else begin
            ld   = paysz_we && m_st == 0;
            wr   = dat_we && !m_full && m_cnt != 0 && !ld;
            pop  = (m_st == 1) && m_full && !m_hp && ser_ready;
            ns   = m_st; st_set = '0; tk_s = 0; tk_h = 0; fl = 0;
            case (m_st)
                0: if (m_hp) begin tk_h = 1; ns = rx_busy ? 4 : 2; end
                   else if (m_sp) begin tk_s = 1; ns = rx_busy ? 3 : 1; end
                1: if (m_hp) begin tk_h = 1; st_set[2] = 1; fl = 1; ns = 2; end
                   else if (m_full) begin
                       if (ser_ready && m_cnt == 0) begin st_set[0] = 1; ns = 0; end
                   end else if (m_cnt == 0) begin st_set[0] = 1; ns = 0; end
                   else if (ser_ready) begin st_set[5] = 1; fl = 1; ns = 0; end
                2: if (hrst_done) begin st_set[3] = 1; ns = 0; end
                3: if (!rx_busy) begin st_set[1] = 1; ns = 0; end
                4: if (!rx_busy) begin st_set[4] = 1; ns = 0; end
                default: ns = 0;
            endcase
            if (fl) begin
                m_cnt = 0; m_full = 0;
            end else begin
                if (ld) m_cnt = int'(paysz_val);
                else if (wr) m_cnt = m_cnt - 1;
                if (pop) m_full = 0;
                else if (wr) begin m_full = 1; m_data = dat_val; end
            end
            m_sp = (m_sp && !tk_s) || cmd_send;
            m_hp = (m_hp && !tk_h) || cmd_hrst;
            m_fl = st_set | (m_fl & ~flag_clr);
            m_st = ns;
        end
    end

    always @(negedge clk) begin : compare
        logic e_val, e_txr;
        if (rst_n) begin
            e_val = (m_st == 1) && m_full && !m_hp;
            e_txr = !m_full && m_cnt != 0;
            chk("R3 ser_valid", 32'(ser_valid), 32'(e_val));
            if (e_val) begin
                chk("R1 ser_data", 32'(ser_data), 32'(m_data));
                chk("R3 ser_last", 32'(ser_last), 32'(m_cnt == 0));
            end
            chk("R2 txreq", 32'(txreq), 32'(e_txr));
            chk("R9 hrst_go", 32'(hrst_go), 32'(m_st == 2));
            chk("R4 cmd_status", 32'(cmd_status), 32'({m_hp, m_sp}));
            chk("R10 stat", 32'(stat), 32'(m_fl));
            chk("R11 irq", 32'(irq), 32'((|(m_fl & irq_en)) || (e_txr && txreq_ie)));
        end
    end

    task automatic cyc();
        @(posedge clk);
        #2;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) cyc();
    endtask

    task automatic load(input int v);
        paysz_we = 1; paysz_val = CNT_W'(v); cyc(); paysz_we = 0;
    endtask

    task automatic wr(input logic [7:0] b);
        dat_we = 1; dat_val = b; cyc(); dat_we = 0;
    endtask

    task automatic send();
        cmd_send = 1; cyc(); cmd_send = 0;
    endtask

    task automatic hrst();
        cmd_hrst = 1; cyc(); cmd_hrst = 0;
    endtask

    task automatic take();
        ser_ready = 1; cyc(); ser_ready = 0;
    endtask

    task automatic hdone();
        hrst_done = 1; cyc(); hrst_done = 0;
    endtask

    task automatic clrall();
        flag_clr = '1; cyc(); flag_clr = '0;
    endtask

    task automatic finish_run();
        $display("[TB] %0d tests run, %0d failed", n_chk, n_bad);
        $finish;
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: run did not complete (all requirements)");
        finish_run();
    end

    initial begin : scenario
        idle(3);
        rst_n = 1;
        chk("R10 reset stat", 32'(stat), 32'h0);
        chk("R2 reset txreq", 32'(txreq), 32'h0);
        chk("R3 reset ser_valid", 32'(ser_valid), 32'h0);
        chk("R4 reset cmd_status", 32'(cmd_status), 32'h0);

        // normal three-byte message, second write while full is dropped
        load(3);
        chk("R2 txreq after load", 32'(txreq), 32'h1);
        wr(8'hA1);
        chk("R2 txreq after write", 32'(txreq), 32'h0);
        wr(8'hB2);
        send();
        idle(2);
        chk("R4 send self-cleared", 32'(cmd_status), 32'h0);
        chk("R3 first byte valid", 32'(ser_valid), 32'h1);
        chk("R1 full write ignored", 32'(ser_data), 32'hA1);
        chk("R3 not last yet", 32'(ser_last), 32'h0);
        take();
        chk("R2 txreq after handoff", 32'(txreq), 32'h1);
        wr(8'hC3);
        take();
        wr(8'hD4);
        chk("R3 last byte marked", 32'(ser_last), 32'h1);
        take();
        chk("R7 sent flag", 32'(stat), 32'h01);
        idle(3);
        chk("R10 flag sticky", 32'(stat), 32'h01);
        flag_clr = 6'b000010; cyc(); flag_clr = '0;
        chk("R10 other clear no effect", 32'(stat), 32'h01);
        clrall();
        chk("R10 cleared", 32'(stat), 32'h00);

        // underrun
        load(2);
        wr(8'h11);
        send();
        idle(2);
        take();
        take();
        chk("R8 underrun flag only", 32'(stat), 32'h20);
        chk("R8 count cleared", 32'(txreq), 32'h0);
        clrall();

        // abort by hard reset
        load(2);
        wr(8'h22);
        send();
        idle(2);
        hrst();
        idle(1);
        chk("R6 abort flag, no sent", 32'(stat), 32'h04);
        chk("R9 hrst_go in HRST", 32'(hrst_go), 32'h1);
        chk("R6 message flushed", 32'(ser_valid), 32'h0);
        hdone();
        chk("R9 hard reset sent", 32'(stat), 32'h0C);
        chk("R9 hrst_go released", 32'(hrst_go), 32'h0);
        clrall();

        // message discard while receiving
        rx_busy = 1;
        load(1);
        wr(8'h33);
        send();
        idle(3);
        chk("R5 discard waits for quiet line", 32'(stat), 32'h00);
        chk("R4 send cleared on discard", 32'(cmd_status), 32'h0);
        rx_busy = 0;
        idle(1);
        chk("R5 discard flag", 32'(stat), 32'h02);
        clrall();

        // hard-reset discard
        rx_busy = 1;
        hrst();
        idle(2);
        chk("R5 hrst discard waits", 32'(stat), 32'h00);
        rx_busy = 0;
        idle(1);
        chk("R5 hrst discard flag", 32'(stat), 32'h10);
        clrall();

        // both commands together: hard reset first, send stays pending
        cmd_send = 1; cmd_hrst = 1; cyc(); cmd_send = 0; cmd_hrst = 0;
        idle(1);
        chk("R4 hrst priority", 32'(cmd_status), 32'h1);
        chk("R9 hrst_go", 32'(hrst_go), 32'h1);
        hdone();
        idle(1);
        chk("R3 leftover byte offered", 32'(ser_data), 32'h33);
        chk("R3 leftover is last", 32'(ser_last), 32'h1);
        take();
        chk("R7 sent after pending send", 32'(stat), 32'h09);
        clrall();

        // zero payload
        load(0);
        send();
        idle(2);
        chk("R7 zero payload sent", 32'(stat), 32'h01);

        // interrupt masking
        irq_en = 6'b000001; cyc();
        chk("R11 irq on enabled flag", 32'(irq), 32'h1);
        irq_en = 6'b111110; cyc();
        chk("R11 irq masked", 32'(irq), 32'h0);
        irq_en = '0;
        clrall();
        load(1);
        txreq_ie = 1; cyc();
        chk("R11 irq from txreq", 32'(irq), 32'h1);
        txreq_ie = 0;
        wr(8'h66);
        send();
        idle(2);
        take();
        clrall();

        // count load ignored outside IDLE
        load(2);
        wr(8'h44);
        send();
        idle(2);
        load(5);
        take();
        wr(8'h55);
        chk("R1 load ignored in MSG", 32'(ser_last), 32'h1);
        take();
        chk("R7 sent", 32'(stat), 32'h01);
        clrall();
        idle(2);
        finish_run();
    end

endmodule